// File: doc/BRIEF.md
# Capture/Compare Timer Channel with Flag Logic

A 16-bit up-counting timer with one channel that works either as an output compare or as an input capture. Its status flags and interrupt enables are reached through a small register bus. The counter runs from zero up to a programmable top value and then returns to zero. Each return to zero raises an update flag.

In compare mode, the channel flag is raised when the counter reaches the value held in the channel register. If the channel register holds a value above the top value, the channel flag is raised on the return to zero instead. In capture mode, the capture pin is first synchronized. An edge of the chosen direction then copies the counter into the channel register and raises the channel flag. If a capture arrives while the channel flag is still set, an overcapture flag is raised.

Software clears a flag by writing zero to its status bit. In capture mode, reading the channel register also clears the channel flag. One interrupt line combines the update flag and the channel flag, each gated by its own enable bit.

Top module: `tmr_capcmp`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: While the run bit (control bit 0) is set, the counter advances by one per clock. When it equals the top value (offset 1), it goes to 0 on the next clock and sets the update flag (status bit 0).
- R3: In compare mode (control bit 1 = 0), a running clock edge at which the counter equals the channel register (offset 2) sets the channel flag (status bit 1).
- R4: In compare mode, when the channel register is above the top value, the channel flag is set by the return to zero and by no other count.
- R5: In capture mode (control bit 1 = 1), an edge on `cap_in` copies the counter into the channel register and sets the channel flag. The edge is seen after a two-flop synchronizer and is rising for control bit 2 = 0 or falling for control bit 2 = 1. Edges of the other direction are ignored. Bus writes to the channel register are ignored in capture mode. In compare mode, `cap_in` has no effect.
- R6: In capture mode, a bus read of the channel register clears the channel flag.
- R7: A capture while the channel flag is set sets the overcapture flag (status bit 9). That flag is never set in compare mode.
- R8: A write to the status register (offset 5) clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R9: If hardware sets a flag at the same clock edge that a status write clears it, the flag ends up set.
- R10: `irq` = (update flag AND enable bit 0) OR (channel flag AND enable bit 1). The enable register is at offset 4. Its other bits read 0.
- R11: Register offsets are 0 control, 1 top value, 2 channel, 3 counter (writable), 4 enables, 5 status. Reads return data in the same cycle as `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 3 | Register offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational on `addr` |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the checker confirms the following:
- the return to zero at the top value and the update flag it raises;
- that a capture always leaves the channel flag set;
- that a capture on a set flag leaves the overcapture flag set;
- that overcapture never rises outside capture mode;
- the gating of `irq` by the enables.

Only the bench scenarios can show the following:
- the exact counter values and register contents after known run windows;
- whether the channel register is above or below the top value;
- edge direction, the read-to-clear side effect, and write-zero-to-clear with write-one ignored;
- the race in which a hardware set lands on the same edge as a software clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_RELOAD = 3'd1,
        REG_CCR    = 3'd2,
        REG_CNT    = 3'd3,
        REG_IEN    = 3'd4,
        REG_STAT   = 3'd5
    } reg_addr_e;

    // control register layout, LSB first: run, capture mode, falling polarity
    typedef struct packed {
        logic pol_fall;
        logic cap_mode;
        logic run;
    } ctrl_t;

    localparam int ST_UPD = 0;
    localparam int ST_CH  = 1;
    localparam int ST_OVR = 9;
    localparam int NFLAG  = 3;

    // index of each flag in the internal flag vector
    localparam int FI_UPD = 0;
    localparam int FI_CH  = 1;
    localparam int FI_OVR = 2;

    function automatic int flag_bit(input int idx);
        case (idx)
            FI_UPD:  return ST_UPD;
            FI_CH:   return ST_CH;
            default: return ST_OVR;
        endcase
    endfunction

    // hardware set dominates software clear
    function automatic logic flag_next(input logic q, input logic hw_set, input logic sw_clr);
        return hw_set | (q & ~sw_clr);
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic pol_fall,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        if (pol_fall) edge_o = prev_q & ~sync_q[STAGES-1];
        else          edge_o = ~prev_q & sync_q[STAGES-1];
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    assign wrap = run && (cnt == reload);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (ld)   cnt <= ld_val;
        else if (wrap) cnt <= '0;
        else if (run)  cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_mode,
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] reload,
    input  logic         wrap,
    input  logic         cap_evt,
    input  logic         wr_ccr,
    input  logic [W-1:0] wval,
    output logic [W-1:0] ccr,
    output logic         ch_set
);
    logic hit;

    always_ff @(posedge clk) begin
        if (rst)                       ccr <= '0;
        else if (cap_mode && cap_evt)  ccr <= cnt;
        else if (!cap_mode && wr_ccr)  ccr <= wval;
    end

    always_comb begin
        if (ccr > reload) hit = wrap;
        else              hit = run && (cnt == ccr);
        ch_set = cap_mode ? cap_evt : hit;
    end
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] hw_set,
    input  logic [NFLAG-1:0] sw_clr,
    output logic [NFLAG-1:0] flags
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) flags[i] <= 1'b0;
            else     flags[i] <= flag_next(flags[i], hw_set[i], sw_clr[i]);
        end
    end
endmodule

// File: rtl/tmr_capcmp.sv
module tmr_capcmp
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cap_in,
    output logic              irq
);
    localparam int IEN_W = 2;

    ctrl_t              ctrl;
    logic [CNT_W-1:0]   reload;
    logic [IEN_W-1:0]   ien;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   ccr;
    logic               wrap;
    logic               cnt_ld;
    logic               cap_evt;
    logic               ch_set;
    logic               run;
    logic               cap_mode;
    logic [NFLAG-1:0]   hw_set;
    logic [NFLAG-1:0]   sw_clr;
    logic [NFLAG-1:0]   flags;
    logic               uif;
    logic               ccif;
    logic               ovf;
    logic               wr_stat;

    assign run      = ctrl.run;
    assign cap_mode = ctrl.cap_mode;
    assign cnt_ld   = wr_en && (addr == REG_CNT);
    assign wr_stat  = wr_en && (addr == REG_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= '0;
            ien    <= '0;
        end else if (wr_en) begin
            case (addr)
                REG_CTRL:   ctrl   <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
                REG_RELOAD: reload <= wdata[CNT_W-1:0];
                REG_IEN:    ien    <= wdata[IEN_W-1:0];
                default:    ;
            endcase
        end
    end

    tmr_edge_sync #(.STAGES(SYNC_N)) i_sync (
        .clk(clk), .rst(rst), .din(cap_in), .pol_fall(ctrl.pol_fall), .edge_o(cap_evt)
    );

    tmr_counter #(.W(CNT_W)) i_cnt (
        .clk(clk), .rst(rst), .run(run), .ld(cnt_ld), .ld_val(wdata[CNT_W-1:0]),
        .reload(reload), .cnt(cnt), .wrap(wrap)
    );

    tmr_chan #(.W(CNT_W)) i_chan (
        .clk(clk), .rst(rst), .cap_mode(cap_mode), .run(run), .cnt(cnt),
        .reload(reload), .wrap(wrap), .cap_evt(cap_evt),
        .wr_ccr(wr_en && (addr == REG_CCR)), .wval(wdata[CNT_W-1:0]),
        .ccr(ccr), .ch_set(ch_set)
    );

    always_comb begin
        hw_set[FI_UPD] = wrap;
        hw_set[FI_CH]  = ch_set;
        hw_set[FI_OVR] = cap_mode && cap_evt && ccif;
        for (int i = 0; i < NFLAG; i++)
            sw_clr[i] = wr_stat && !wdata[flag_bit(i)];
        if (rd_en && cap_mode && (addr == REG_CCR))
            sw_clr[FI_CH] = 1'b1;
    end

    tmr_flags i_flags (
        .clk(clk), .rst(rst), .hw_set(hw_set), .sw_clr(sw_clr), .flags(flags)
    );

    assign uif  = flags[FI_UPD];
    assign ccif = flags[FI_CH];
    assign ovf  = flags[FI_OVR];
    assign irq  = (uif & ien[0]) | (ccif & ien[1]);

    always_comb begin
        rdata = '0;
        case (addr)
            REG_CTRL:   rdata = DATA_W'(ctrl);
            REG_RELOAD: rdata = DATA_W'(reload);
            REG_CCR:    rdata = DATA_W'(ccr);
            REG_CNT:    rdata = DATA_W'(cnt);
            REG_IEN:    rdata = DATA_W'(ien);
            REG_STAT: begin
                rdata[ST_UPD] = uif;
                rdata[ST_CH]  = ccif;
                rdata[ST_OVR] = ovf;
            end
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_capcmp_chk.sv
module tmr_capcmp_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             cnt_ld,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             cap_mode,
    input logic             cap_evt,
    input logic             uif,
    input logic             ccif,
    input logic             ovf,
    input logic [1:0]       ien,
    input logic             irq
);
    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == reload && !cnt_ld) |=> (cnt == '0 && uif));

    // R5
    cap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_mode && cap_evt) |=> ccif);

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_mode && cap_evt && ccif) |=> ovf);

    // R7
    ovr_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(cap_mode));

    // R10
    irq_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ien == 2'b00) |-> !irq);

    // R10
    irq_on_chk: assert property (@(posedge clk) disable iff (rst)
        ((uif && ien[0]) || (ccif && ien[1])) |-> irq);
endmodule

bind tmr_capcmp tmr_capcmp_chk #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst(rst), .run(run), .cnt_ld(cnt_ld), .cnt(cnt), .reload(reload),
    .cap_mode(cap_mode), .cap_evt(cap_evt), .uif(uif), .ccif(ccif), .ovf(ovf),
    .ien(ien), .irq(irq)
);

// File: tb/test_tmr_capcmp.sv
module test_tmr_capcmp;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_CTRL = 3'd0, A_RELOAD = 3'd1, A_CCR = 3'd2,
                           A_CNT = 3'd3, A_IEN = 3'd4, A_STAT = 3'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        cap_in = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [2:0]  a;
        logic [15:0] v;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_capcmp i_tmr_capcmp (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .irq(irq)
    );

    // monitor: compares each read against the oldest expected item
    always @(negedge clk) begin
        exp_t e;
        if (rd_en) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: read addr %0d got %h", addr, rdata);
            end else begin
                e = sb.pop_front();
                if (rdata !== e.v || addr !== e.a) begin
                    errors++;
                    $display("FAIL %s: addr %0d actual %h expected %h", e.tag, e.a, rdata, e.v);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] v, input string tag);
        @(posedge clk); #1;
        sb.push_back('{a, v, tag});
        rd_en = 1'b1; addr = a;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic v, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== v) begin
            errors++;
            $display("FAIL %s: irq actual %b expected %b", tag, irq, v);
        end
    endtask

    // two running clock edges, then stop; keeps the given mode bits
    task automatic pulse2(input logic [15:0] mode);
        wr(A_CTRL, mode | 16'h1);
        wr(A_CTRL, mode);
    endtask

    task automatic waitn(input int n);
        repeat (n) @(posedge clk);
    endtask

    logic done = 1'b0;

    initial begin
        waitn(20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        waitn(3);
        #1 rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, 16'h0, "R1 ctrl");
        rd(A_RELOAD, 16'h0, "R1 reload");
        rd(A_CCR, 16'h0, "R1 ccr");
        rd(A_CNT, 16'h0, "R1 cnt");
        rd(A_IEN, 16'h0, "R1 ien");
        rd(A_STAT, 16'h0, "R1 stat");
        chk_irq(1'b0, "R1 irq");

        // R2 wrap to zero sets update flag
        wr(A_RELOAD, 16'd4);
        wr(A_CCR, 16'd3);
        wr(A_CNT, 16'd4);
        pulse2(16'h0);
        rd(A_CNT, 16'd1, "R2 count after wrap");
        rd(A_STAT, 16'h0001, "R2 update flag");

        // R10 interrupt gating, R11 enable readback
        wr(A_IEN, 16'h0001);
        chk_irq(1'b1, "R10 update enabled");
        rd(A_IEN, 16'h0001, "R10 ien readback");
        wr(A_IEN, 16'hFFFF);
        rd(A_IEN, 16'h0003, "R10 ien reserved bits");
        wr(A_IEN, 16'h0002);
        chk_irq(1'b0, "R10 update masked");

        // R8 write one keeps, write zero clears
        wr(A_STAT, 16'hFFFF);
        rd(A_STAT, 16'h0001, "R8 write ones no effect");
        wr(A_STAT, 16'h0000);
        rd(A_STAT, 16'h0000, "R8 write zero clears");

        // R3 compare match
        wr(A_CNT, 16'd2);
        pulse2(16'h0);
        rd(A_STAT, 16'h0002, "R3 compare flag");
        rd(A_CNT, 16'd4, "R3 count");
        chk_irq(1'b1, "R10 channel enabled");
        wr(A_STAT, 16'h0000);
        wr(A_IEN, 16'h0000);

        // R4 compare above top value
        wr(A_CCR, 16'd10);
        wr(A_CNT, 16'd0);
        pulse2(16'h0);
        rd(A_STAT, 16'h0000, "R4 no flag before wrap");
        wr(A_CNT, 16'd3);
        pulse2(16'h0);
        rd(A_STAT, 16'h0003, "R4 flag on wrap");
        wr(A_STAT, 16'hFFFD);
        rd(A_STAT, 16'h0001, "R8 selective clear");
        wr(A_STAT, 16'h0000);

        // R9 hardware set beats software clear in the same cycle
        wr(A_CCR, 16'd2);
        wr(A_CNT, 16'd3);
        wr(A_CTRL, 16'h0001);
        wr(A_STAT, 16'h0000);
        wr(A_CTRL, 16'h0000);
        rd(A_STAT, 16'h0001, "R9 set wins");
        wr(A_STAT, 16'h0000);

        // R5/R7 capture pin ignored in compare mode
        cap_in = 1'b1; waitn(6);
        cap_in = 1'b0; waitn(6);
        rd(A_STAT, 16'h0000, "R7 no flags in compare mode");
        rd(A_CCR, 16'd2, "R5 compare mode ignores pin");

        // R5 rising capture, R6 read clears
        wr(A_CTRL, 16'h0002);
        wr(A_CNT, 16'd7);
        cap_in = 1'b1; waitn(6);
        rd(A_STAT, 16'h0002, "R5 rising capture flag");
        rd(A_CCR, 16'd7, "R5 captured value");
        rd(A_STAT, 16'h0000, "R6 read clears flag");
        cap_in = 1'b0; waitn(6);
        rd(A_STAT, 16'h0000, "R5 falling edge ignored");

        // R5 falling polarity
        wr(A_CTRL, 16'h0006);
        wr(A_CNT, 16'd9);
        cap_in = 1'b1; waitn(6);
        rd(A_STAT, 16'h0000, "R5 rising ignored when falling selected");
        cap_in = 1'b0; waitn(6);
        rd(A_STAT, 16'h0002, "R5 falling capture flag");
        rd(A_CCR, 16'd9, "R5 falling captured value");
        wr(A_CCR, 16'h0055);
        rd(A_CCR, 16'd9, "R5 bus write ignored in capture mode");

        // R7 overcapture
        wr(A_CTRL, 16'h0002);
        wr(A_CNT, 16'd5);
        cap_in = 1'b1; waitn(6);
        cap_in = 1'b0; waitn(6);
        wr(A_CNT, 16'd6);
        cap_in = 1'b1; waitn(6);
        rd(A_STAT, 16'h0202, "R7 overcapture");
        rd(A_CCR, 16'd6, "R7 latest capture");
        rd(A_STAT, 16'h0200, "R6 read clears channel only");
        wr(A_STAT, 16'h0000);
        rd(A_STAT, 16'h0000, "R8 overcapture cleared");

        waitn(2);
        done = 1'b1;
        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard leftover: actual %0d expected 0", sb.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule